// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and repeats either one instruction or a contiguous run of instructions a programmed number of times. No branch instruction runs on any pass. The decoder hands it a repeat command. The command carries the address of the repeat instruction itself, a mode bit, an iteration count and, for the block mode, the address of the last instruction in the body. The body always begins at the word that follows the repeat instruction.

The controller compares the fetch address against the body's last address on every advancing fetch. While passes remain, it steers the next fetch address back to the body start. A down-counter of remaining extra passes steps once per completed pass. Accepting a command raises a one-cycle refill request; that is the only fetch disturbance the loop ever causes. The last fetch of the final pass raises a one-cycle completion pulse. A command that arrives while a loop runs is dropped and an error pulse is raised. Only one loop level exists.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `flush`, `loop_active`, `loop_done` and `cmd_err` are all low.
- R2: A command with `cmd_valid` high while no loop is active is accepted. `flush` is high for exactly the one cycle that follows acceptance and is low otherwise.
- R3: With `cmd_mode` = 0 (single), the body is only the instruction at `cmd_pc`+1.
- R4: With `cmd_mode` = 1 (block), the body runs from `cmd_pc`+1 through `cmd_end`. When the fetch address equals the body end and passes remain, `next_pc` is the body start in the same cycle.
- R5: A count N of 2 or more makes the body execute N times in total. `loop_active` is high from the cycle after acceptance until the cycle after the final pass ends.
- R6: A count of 0 or 1 makes the body execute once with plain sequential fetch. `loop_active` stays low and `loop_done` never rises.
- R7: `loop_done` is high for one cycle, combinationally, when a valid fetch of the body end occurs on the final pass of an active loop. `loop_active` is low in the next cycle.
- R8: While `fetch_valid` is low, no redirect occurs (`next_pc` = `fetch_pc`+1) and the pass count does not change.
- R9: A command presented while a loop is active is ignored. The loop's body, count and mode are unchanged, `flush` stays low, and `cmd_err` is high in the following cycle.
- R10: Outside a redirect, `next_pc` is `fetch_pc`+1 modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Repeat command present |
| cmd_mode | input | 1 | 0 = single instruction, 1 = block |
| cmd_pc | input | AW | Address of the repeat instruction |
| cmd_end | input | AW | Last body address (block mode) |
| cmd_count | input | CW | Total iteration count |
| fetch_valid | input | 1 | Fetch advances this cycle |
| fetch_pc | input | AW | Current fetch address |
| next_pc | output | AW | Next fetch address |
| flush | output | 1 | One-cycle refill request after setup |
| loop_active | output | 1 | A loop is running |
| loop_done | output | 1 | Final pass's last instruction fetched |
| cmd_err | output | 1 | Command was rejected in the previous cycle |

## Verification
The bench builds the controller with AW = 8 and CW = 4. With those widths a loop at the largest count, 15, runs in a few dozen cycles, so the full range of the counter is exercised. The address wrap from 0xFF to 0x00 can also be driven directly. The narrow address makes the sequential-increment corner as cheap to reach as the loop traces themselves.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic {
        RPT_ONE   = 1'b0,
        RPT_RANGE = 1'b1
    } rpt_mode_e;

    typedef enum logic {
        LP_IDLE = 1'b0,
        LP_RUN  = 1'b1
    } lp_state_e;

    typedef struct packed {
        logic accept;
        logic reject;
        logic arm;
    } cmd_verdict_t;

    function automatic cmd_verdict_t judge(input logic valid, input logic busy,
                                           input logic multi);
        cmd_verdict_t v;
        v.accept = valid && !busy;
        v.reject = valid && busy;
        v.arm    = valid && !busy && multi;
        return v;
    endfunction

endpackage

// File: rtl/hwloop_cmd.sv
module hwloop_cmd
    import hwloop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_mode,
    input  logic [AW-1:0] cmd_pc,
    input  logic [AW-1:0] cmd_end,
    input  logic [CW-1:0] cmd_count,
    input  logic          busy,
    output logic          take,
    output logic          arm,
    output logic [AW-1:0] body_start,
    output logic [AW-1:0] body_stop,
    output logic [CW-1:0] extra,
    output logic          flush,
    output logic          err
);

    cmd_verdict_t verdict;
    rpt_mode_e    mode;

    always_comb begin
        mode       = rpt_mode_e'(cmd_mode);
        verdict    = judge(cmd_valid, busy, |cmd_count[CW-1:1]);
        take       = verdict.accept;
        arm        = verdict.arm;
        body_start = cmd_pc + AW'(1);
        body_stop  = (mode == RPT_ONE) ? body_start : cmd_end;
        extra      = cmd_count - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush <= 1'b0;
            err   <= 1'b0;
        end else begin
            flush <= verdict.accept;
            err   <= verdict.reject;
        end
    end

endmodule

// File: rtl/hwloop_counter.sv
module hwloop_counter
    import hwloop_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          arm,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  logic          last,
    output logic          active,
    output logic          rem_zero
);

    lp_state_e     state;
    logic [CW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LP_IDLE;
            rem   <= '0;
        end else if (load) begin
            state <= arm ? LP_RUN : LP_IDLE;
            rem   <= load_val;
        end else if (state == LP_RUN) begin
            if (last) begin
                state <= LP_IDLE;
            end else if (step) begin
                rem <= rem - CW'(1);
            end
        end
    end

    assign active   = (state == LP_RUN);
    assign rem_zero = (rem == '0);

endmodule

// File: rtl/hwloop_redirect.sv
module hwloop_redirect #(
    parameter int AW = 16
) (
    input  logic          active,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic [AW-1:0] body_start,
    input  logic [AW-1:0] body_stop,
    input  logic          rem_zero,
    output logic [AW-1:0] next_pc,
    output logic          step,
    output logic          last
);

    logic at_end;

    always_comb begin
        at_end  = active && fetch_valid && (fetch_pc == body_stop);
        step    = at_end && !rem_zero;
        last    = at_end && rem_zero;
        next_pc = step ? body_start : fetch_pc + AW'(1);
    end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_mode,
    input  logic [AW-1:0] cmd_pc,
    input  logic [AW-1:0] cmd_end,
    input  logic [CW-1:0] cmd_count,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc,
    output logic          flush,
    output logic          loop_active,
    output logic          loop_done,
    output logic          cmd_err
);

    logic          take, arm, step, last, rem_zero;
    logic [AW-1:0] new_start, new_stop;
    logic [AW-1:0] lp_start, lp_stop;
    logic [CW-1:0] extra;

    hwloop_cmd #(.AW(AW), .CW(CW)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_mode   (cmd_mode),
        .cmd_pc     (cmd_pc),
        .cmd_end    (cmd_end),
        .cmd_count  (cmd_count),
        .busy       (loop_active),
        .take       (take),
        .arm        (arm),
        .body_start (new_start),
        .body_stop  (new_stop),
        .extra      (extra),
        .flush      (flush),
        .err        (cmd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_start <= '0;
            lp_stop  <= '0;
        end else if (take) begin
            lp_start <= new_start;
            lp_stop  <= new_stop;
        end
    end

    hwloop_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .arm      (arm),
        .load_val (extra),
        .step     (step),
        .last     (last),
        .active   (loop_active),
        .rem_zero (rem_zero)
    );

    hwloop_redirect #(.AW(AW)) u_redir (
        .active      (loop_active),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .body_start  (lp_start),
        .body_stop   (lp_stop),
        .rem_zero    (rem_zero),
        .next_pc     (next_pc),
        .step        (step),
        .last        (last)
    );

    assign loop_done = last;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          fetch_valid,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] next_pc,
    input logic          flush,
    input logic          loop_active,
    input logic          loop_done,
    input logic          cmd_err
);

    p_flush_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        flush |-> ($past(cmd_valid) && !$past(loop_active)));

    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> ($past(cmd_valid) && $past(loop_active)));

    p_busy_no_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && loop_active) |=> !flush);

    p_done_in_loop_r7: assert property (@(posedge clk) disable iff (rst)
        loop_done |-> (loop_active && fetch_valid));

    p_done_ends_loop_r7: assert property (@(posedge clk) disable iff (rst)
        loop_done |=> !loop_active);

    p_stall_no_jump_r8: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> (next_pc == fetch_pc + AW'(1)));

    p_idle_sequential_r10: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> (next_pc == fetch_pc + AW'(1)));

    p_busy_keeps_loop_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && loop_active && !loop_done) |=> loop_active);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .next_pc     (next_pc),
    .flush       (flush),
    .loop_active (loop_active),
    .loop_done   (loop_done),
    .cmd_err     (cmd_err)
);

// File: tb/hwloop_ctrl_test.sv
`timescale 1ns/1ps
module hwloop_ctrl_test;
    localparam int AW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid, cmd_mode, fetch_valid;
    logic [AW-1:0] cmd_pc, cmd_end, fetch_pc, next_pc;
    logic [CW-1:0] cmd_count;
    logic          flush, loop_active, loop_done, cmd_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hwloop_ctrl #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_pc(cmd_pc), .cmd_end(cmd_end), .cmd_count(cmd_count),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .flush(flush), .loop_active(loop_active), .loop_done(loop_done),
        .cmd_err(cmd_err)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid = 1'b0; cmd_mode = 1'b0; cmd_pc = '0; cmd_end = '0;
        cmd_count = '0; fetch_valid = 1'b0; fetch_pc = '0;
    endtask

    // Issues one command and walks the whole expected fetch trace.
    task automatic run_loop(input logic mode, input logic [AW-1:0] pc0,
                            input logic [AW-1:0] endp, input logic [CW-1:0] cnt,
                            input int stall_at, input bit inject);
        logic [AW-1:0] start, stop, pc, exp_next;
        int  passes, pass;
        bit  armed, exp_wrap, exp_done, fin, injected, err_due;
        start = pc0 + AW'(1);
        stop  = mode ? endp : start;
        armed = (cnt >= CW'(2));
        passes = armed ? int'(cnt) : 1;
        fin = 1'b0; injected = 1'b0; err_due = 1'b0;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode; cmd_pc = pc0; cmd_end = endp;
        cmd_count = cnt; fetch_valid = 1'b1; fetch_pc = pc0;
        #1;
        check("R10 next_pc at command", 32'(next_pc), 32'(start));
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 flush after accept", 32'(flush), 32'd1);
        check("R5 R6 active after accept", 32'(loop_active), 32'(armed));

        pc = start; pass = 1;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            fetch_pc = pc;
            if (cyc == stall_at) begin
                fetch_valid = 1'b0;
                #1;
                check("R8 stall next_pc", 32'(next_pc), 32'(pc + AW'(1)));
                check("R8 stall done", 32'(loop_done), 32'd0);
                @(posedge clk); @(negedge clk);
                fetch_valid = 1'b1;
            end
            if (inject && pass == 2 && pc == start && !injected) begin
                cmd_valid = 1'b1; cmd_mode = ~mode; cmd_pc = pc0 + AW'(9);
                cmd_end = pc0 + AW'(12); cmd_count = CW'(1);
                injected = 1'b1;
            end
            #1;
            exp_wrap = armed && (pc == stop) && (pass < passes);
            exp_done = armed && (pc == stop) && (pass == passes);
            exp_next = exp_wrap ? start : pc + AW'(1);
            check(mode ? "R4 next_pc block" : "R3 next_pc single", 32'(next_pc), 32'(exp_next));
            check("R7 loop_done", 32'(loop_done), 32'(exp_done));
            check("R5 loop_active in body", 32'(loop_active), 32'(armed));
            if (cyc == 1) check("R2 flush single cycle", 32'(flush), 32'd0);
            if (err_due) begin
                check("R9 cmd_err after busy command", 32'(cmd_err), 32'd1);
                check("R9 no flush for busy command", 32'(flush), 32'd0);
                err_due = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            if (cmd_valid) begin
                cmd_valid = 1'b0;
                err_due = 1'b1;
            end
            if (pc == stop) begin
                if (pass == passes) fin = 1'b1;
                else begin pass++; pc = start; end
            end else begin
                pc = pc + AW'(1);
            end
        end
        fetch_pc = stop + AW'(1);
        #1;
        check("R7 inactive after loop", 32'(loop_active), 32'd0);
        check("R6 no done after loop", 32'(loop_done), 32'd0);
        check("R10 sequential after loop", 32'(next_pc), 32'(stop + AW'(2)));
        if (inject) check("R9 injected command ignored", 32'(injected), 32'd1);
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 flush in reset", 32'(flush), 32'd0);
        check("R1 active in reset", 32'(loop_active), 32'd0);
        check("R1 done in reset", 32'(loop_done), 32'd0);
        check("R1 err in reset", 32'(cmd_err), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 active after reset", 32'(loop_active), 32'd0);
        check("R1 flush after reset", 32'(flush), 32'd0);
        check("R1 err after reset", 32'(cmd_err), 32'd0);
    endtask

    task automatic t_addr_wrap();
        @(negedge clk);
        fetch_valid = 1'b1; fetch_pc = 8'hFF;
        #1;
        check("R10 address wrap", 32'(next_pc), 32'h00);
        fetch_pc = 8'h7C;
        #1;
        check("R10 idle increment", 32'(next_pc), 32'h7D);
        fetch_valid = 1'b0;
    endtask

    task automatic t_single();     run_loop(1'b0, 8'h10, 8'h00, 4'd4, -1, 1'b0); endtask
    task automatic t_block();      run_loop(1'b1, 8'h20, 8'h24, 4'd3, -1, 1'b0); endtask
    task automatic t_small();
        run_loop(1'b1, 8'h30, 8'h32, 4'd0, -1, 1'b0);
        run_loop(1'b0, 8'h38, 8'h00, 4'd1, -1, 1'b0);
    endtask
    task automatic t_max_count();  run_loop(1'b0, 8'h60, 8'h00, 4'd15, -1, 1'b0); endtask
    task automatic t_stall();      run_loop(1'b1, 8'h40, 8'h42, 4'd2, 1, 1'b0); endtask
    task automatic t_busy();       run_loop(1'b1, 8'h50, 8'h52, 4'd3, -1, 1'b1); endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        t_reset();
        t_addr_wrap();
        t_single();
        t_block();
        t_small();
        t_max_count();
        t_stall();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog R5 actual=hung expected=loop completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule